// File: doc/BRIEF.md
# MSI Capability Registers with Interrupt Steering

This block holds the Message Signaled Interrupt capability of a PCI Express port's configuration space and chooses the delivery path for a port interrupt event. Software reaches three registers through a small configuration port: dword address, per-byte write enables, write data, and combinational read data. The three registers are a read-only identifier word, a message control word, and a 32-bit message address.

An interrupt event input and the bus-master-enable bit from the command register decide the outcome of each event. The block can raise one 32-bit MSI write request, which carries the programmed address and a fixed data word. It can instead drive a level on a legacy interrupt pin. It can also drop the event. The multiple-message enable field can be written but has no effect, so exactly one vector is ever produced. When MSI is enabled and bus mastering is off, the block produces no interrupt of any kind.

Top module: `msi_cap_steer`

## Requirements
- R1: The dword at byte offset 80h (dword address 20h) reads 9005h in bits 15:0: capability ID 05h in bits 7:0 and next pointer 90h in bits 15:8. Writes to those bytes are ignored.
- R2: The control word occupies bits 31:16 of dword 20h and resets to 0000h. Its bits 15:8 (bus bits 31:24), bit 7 (64-bit capable) and bits 3:1 (messages capable) always read 0.
- R3: Control bits 6:4 (bus bits 22:20) can be written and read back. Whatever their value, each qualifying event gives exactly one MSI request.
- R4: Control bit 0 (bus bit 16) is MSI enable, reset 0, and can be read and written. While it is 1, the legacy pin output is 0.
- R5: A rising edge of the interrupt event, sampled at a clock edge while MSI enable and bus master enable are both 1, gives a one-cycle MSI request in the following cycle. The request carries the address register value from before that edge and the fixed data word.
- R6: While MSI enable is 1 and bus master enable is 0, neither an MSI request nor the legacy pin is produced. A dropped event is not queued: raising bus master enable later, with the event still high, produces nothing.
- R7: While MSI enable is 0, the legacy pin equals the event input whatever bus master enable is, and no MSI request is made.
- R8: The message address at dword 21h (byte 84h) resets to 0. Bits 31:2 can be read and written. Bits 1:0 read 0 and ignore writes.
- R9: A write changes only the byte lanes whose enable bit is set (bit i covers data bits 8i+7:8i).
- R10: Reads of any dword address other than 20h and 21h return 0. Writes to them change no register.
- R11: A write shows in read data only after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Dword address of the access |
| cfg_wbe | input | 4 | Byte-lane write enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| irq_event | input | 1 | Port interrupt event level |
| bus_master_en | input | 1 | Bus master enable from the command register |
| msi_req | output | 1 | One-cycle MSI write request |
| msi_addr | output | 32 | Address of the MSI write |
| msi_data | output | 32 | Fixed data of the MSI write |
| intx_level | output | 1 | Legacy interrupt pin level |

## Verification
The bench uses the default parameters: a 6-bit dword address, the capability at byte 80h, and next pointer 90h. A 6-bit address lets it walk dwords on both sides of the capability, so reads and writes just outside 80h–87h are covered. The default data word is a nonzero constant, so a request sent with the wrong data can be seen. The cycle-accurate model tracks every combination of MSI enable and bus master enable, including dropped events and events that toggle every cycle.

// File: rtl/msi_cap_pkg.sv
// Package: shared constants and types for the MSI capability block.
// Assumes a 32-bit configuration data path with four byte lanes.
package msi_cap_pkg;
    localparam int          DW_BITS    = 32;
    localparam int          LANES      = DW_BITS / 8;
    localparam logic [7:0]  MSI_CAP_ID = 8'h05;

    typedef struct packed {
        logic [2:0] mme;   // requested message count, stored only
        logic       en;    // MSI enable
    } msi_ctrl_t;
endpackage

// File: rtl/msi_cap_regs.sv
// Module: configuration register file of the MSI capability.
// Holds the control bits and the dword-aligned message address, and
// decodes reads. Assumes the capability starts on a dword boundary.
module msi_cap_regs
    import msi_cap_pkg::*;
#(
    parameter int         ADDR_W       = 6,
    parameter int         CAP_BYTE_OFS = 'h80,
    parameter logic [7:0] NEXT_PTR     = 8'h90
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [LANES-1:0]     cfg_wbe,
    input  logic [DW_BITS-1:0]   cfg_wdata,
    output logic [DW_BITS-1:0]   cfg_rdata,
    output msi_ctrl_t            ctrl,
    output logic [DW_BITS-1:0]   msg_addr
);
    localparam int                CTRL_DW  = CAP_BYTE_OFS / 4;
    localparam int                ADR_DW   = CTRL_DW + 1;
    localparam logic [ADDR_W-1:0] CTRL_SEL = ADDR_W'(CTRL_DW);
    localparam logic [ADDR_W-1:0] ADR_SEL  = ADDR_W'(ADR_DW);

    logic              hit_ctrl;
    logic              hit_adr;
    logic [DW_BITS-1:2] adr_q;

    assign hit_ctrl = (cfg_addr == CTRL_SEL);
    assign hit_adr  = (cfg_addr == ADR_SEL);

    // Control byte update: only the lane holding control bits 7:0 is writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (cfg_wr && hit_ctrl && cfg_wbe[2]) begin
            ctrl.mme <= cfg_wdata[22:20];
            ctrl.en  <= cfg_wdata[16];
        end
    end

    // Address register: one writable slice per byte lane; bits 1:0 are not stored.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        localparam int LO = (ln == 0) ? 2 : 8 * ln;
        localparam int HI = 8 * ln + 7;
        // Per-lane address byte update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                adr_q[HI:LO] <= '0;
            end else if (cfg_wr && hit_adr && cfg_wbe[ln]) begin
                adr_q[HI:LO] <= cfg_wdata[HI:LO];
            end
        end
    end

    assign msg_addr = {adr_q, 2'b00};

    // Read decode: unmapped dwords return zero.
    always_comb begin
        cfg_rdata = '0;
        if (hit_ctrl) begin
            cfg_rdata = {8'h00, 1'b0, ctrl.mme, 3'b000, ctrl.en,
                         NEXT_PTR, MSI_CAP_ID};
        end else if (hit_adr) begin
            cfg_rdata = msg_addr;
        end
    end
endmodule

// File: rtl/msi_irq_steer.sv
// Module: steers a port interrupt event to MSI, the legacy pin, or nowhere.
// Assumes msi_en and msg_addr come from registers of the same clock domain.
module msi_irq_steer
    import msi_cap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_event,
    input  logic               bus_master_en,
    input  logic               msi_en,
    input  logic [DW_BITS-1:0] msg_addr,
    output logic               msi_req,
    output logic [DW_BITS-1:0] msi_addr,
    output logic               intx_level
);
    logic evt_q;
    logic fire;

    assign fire = irq_event && !evt_q && msi_en && bus_master_en;

    // Edge history of the event input.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= irq_event;
    end

    // One-cycle request with the address captured at the firing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msi_req  <= 1'b0;
            msi_addr <= '0;
        end else begin
            msi_req <= fire;
            if (fire) msi_addr <= msg_addr;
        end
    end

    // Legacy pin used only while MSI is off.
    assign intx_level = irq_event && !msi_en;
endmodule

// File: rtl/msi_cap_steer.sv
// Module: top of the MSI capability and interrupt steering block.
// Assumes a single clock and synchronous active-low reset.
module msi_cap_steer
    import msi_cap_pkg::*;
#(
    parameter int          ADDR_W       = 6,
    parameter int          CAP_BYTE_OFS = 'h80,
    parameter logic [7:0]  NEXT_PTR     = 8'h90,
    parameter logic [31:0] MSG_DATA     = 32'h0000_4A21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_wbe,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              irq_event,
    input  logic              bus_master_en,
    output logic              msi_req,
    output logic [31:0]       msi_addr,
    output logic [31:0]       msi_data,
    output logic              intx_level
);
    msi_ctrl_t   ctrl;
    logic        msi_en;
    logic [31:0] msg_addr;

    msi_cap_regs #(
        .ADDR_W(ADDR_W), .CAP_BYTE_OFS(CAP_BYTE_OFS), .NEXT_PTR(NEXT_PTR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wbe(cfg_wbe), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ctrl(ctrl), .msg_addr(msg_addr)
    );

    assign msi_en   = ctrl.en;
    assign msi_data = MSG_DATA;

    msi_irq_steer u_steer (
        .clk(clk), .rst_n(rst_n), .irq_event(irq_event),
        .bus_master_en(bus_master_en), .msi_en(msi_en), .msg_addr(msg_addr),
        .msi_req(msi_req), .msi_addr(msi_addr), .intx_level(intx_level)
    );
endmodule

// File: rtl/msi_cap_steer_chk.sv
// Module: property checker bound to msi_cap_steer.
// Assumes the default capability placement (dword 20h).
module msi_cap_steer_chk #(
    parameter int ADDR_W  = 6,
    parameter int CTRL_DW = 'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [31:0]       cfg_rdata,
    input logic              irq_event,
    input logic              bus_master_en,
    input logic              msi_en,
    input logic              msi_req,
    input logic [31:0]       msi_addr,
    input logic              intx_level
);
    localparam logic [ADDR_W-1:0] C_SEL = ADDR_W'(CTRL_DW);
    localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(CTRL_DW + 1);

    assert_id_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == C_SEL) |-> (cfg_rdata[15:0] == 16'h9005));

    assert_ctrl_ro_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == C_SEL) |-> (cfg_rdata[31:23] == 9'h0 && cfg_rdata[19:17] == 3'b000));

    assert_no_legacy_in_msi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        msi_en |-> !intx_level);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |=> !msi_req);

    assert_req_after_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msi_req) |-> $past(irq_event));

    assert_req_needs_bme_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msi_req) |-> ($past(bus_master_en) && $past(msi_en)));

    assert_addr_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> (msi_addr[1:0] == 2'b00));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr != C_SEL && cfg_addr != A_SEL) |-> (cfg_rdata == 32'h0));
endmodule

bind msi_cap_steer msi_cap_steer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
    .irq_event(irq_event), .bus_master_en(bus_master_en), .msi_en(msi_en),
    .msi_req(msi_req), .msi_addr(msi_addr), .intx_level(intx_level)
);

// File: tb/msi_cap_steer_tb.sv
// Bench: behavioural cycle model compared on every clock, plus directed checks.
module msi_cap_steer_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] DATA_EXP   = 32'h0000_4A21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_wbe = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq_event = 1'b0;
    logic        bus_master_en = 1'b0;
    logic        msi_req;
    logic [31:0] msi_addr;
    logic [31:0] msi_data;
    logic        intx_level;

    int total = 0;
    int bad   = 0;
    int pulses = 0;
    int intx_hits = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_cap_steer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wbe(cfg_wbe), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_event(irq_event), .bus_master_en(bus_master_en),
        .msi_req(msi_req), .msi_addr(msi_addr), .msi_data(msi_data),
        .intx_level(intx_level)
    );

    // Reference model state.
    logic        m_en;
    logic [2:0]  m_mme;
    logic [31:0] m_adr;
    logic        m_evt;
    logic        m_req;
    logic [31:0] m_radr;

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        if (a == 6'h20) return {8'h00, 1'b0, m_mme, 3'b000, m_en, 16'h9005};
        if (a == 6'h21) return m_adr;
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en <= 0; m_mme <= 0; m_adr <= 0; m_evt <= 0; m_req <= 0; m_radr <= 0;
        end else begin
            if (cfg_wr && cfg_addr == 6'h20 && cfg_wbe[2]) begin
                m_en  <= cfg_wdata[16];
                m_mme <= cfg_wdata[22:20];
            end
            if (cfg_wr && cfg_addr == 6'h21) begin
                logic [31:0] nxt;
                nxt = m_adr;
                for (int i = 0; i < 4; i++)
                    if (cfg_wbe[i]) nxt[8*i +: 8] = cfg_wdata[8*i +: 8];
                nxt[1:0] = 2'b00;
                m_adr <= nxt;
            end
            m_evt <= irq_event;
            m_req <= irq_event && !m_evt && m_en && bus_master_en;
            if (irq_event && !m_evt && m_en && bus_master_en) m_radr <= m_adr;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R9 read data", cfg_rdata, exp_rd(cfg_addr));
            check("R5 msi_req", {31'b0, msi_req}, {31'b0, m_req});
            if (m_req) begin
                check("R5 msi_addr", msi_addr, m_radr);
                check("R5 msi_data", msi_data, DATA_EXP);
            end
            check("R7 intx_level", {31'b0, intx_level}, {31'b0, irq_event && !m_en});
            if (msi_req) pulses++;
            if (intx_level) intx_hits++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        cfg_addr = a; cfg_wbe = be; cfg_wdata = d; cfg_wr = 1'b1;
        tick();
        cfg_wr = 1'b0; cfg_wbe = '0;
    endtask

    task automatic rd(input logic [5:0] a, input string tag, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic finish_up();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        int p0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // Reset state
        rd(6'h20, "R1 R2 reset id/control", 32'h0000_9005);
        rd(6'h21, "R8 reset address", 32'h0);
        check("R4 reset intx", {31'b0, intx_level}, 32'h0);
        // Read-only id bytes
        cfg_write(6'h20, 4'b0011, 32'hFFFF_FFFF);
        rd(6'h20, "R1 id ignores writes", 32'h0000_9005);
        // Write timing: value not visible before the accepting edge
        cfg_addr = 6'h20; cfg_wbe = 4'b0100; cfg_wdata = 32'h00FF_0000; cfg_wr = 1'b1;
        #1;
        check("R11 before edge", cfg_rdata, 32'h0000_9005);
        tick();
        cfg_wr = 1'b0; cfg_wbe = '0;
        rd(6'h20, "R11 R2 R3 R4 after edge", 32'h0071_9005);
        cfg_write(6'h20, 4'b1000, 32'hFF00_0000);
        rd(6'h20, "R2 reserved byte", 32'h0071_9005);
        // Address register and lanes
        cfg_write(6'h21, 4'b1111, 32'h1234_5677);
        rd(6'h21, "R8 aligned address", 32'h1234_5674);
        cfg_write(6'h21, 4'b0010, 32'hFFFF_ABFF);
        rd(6'h21, "R9 single lane", 32'h1234_AB74);
        // MSI with MME=7: one request per edge
        bus_master_en = 1'b1;
        p0 = pulses; intx_hits = 0;
        irq_event = 1'b1; repeat (4) tick();
        irq_event = 1'b0; repeat (2) tick();
        check("R3 R5 one request", pulses - p0, 1);
        check("R4 no legacy in MSI mode", intx_hits, 0);
        // Toggling event every cycle
        p0 = pulses;
        for (int k = 0; k < 5; k++) begin
            irq_event = 1'b1; tick();
            irq_event = 1'b0; tick();
        end
        tick();
        check("R5 request per edge", pulses - p0, 5);
        // Bus mastering off: dropped, not queued
        bus_master_en = 1'b0;
        p0 = pulses; intx_hits = 0;
        irq_event = 1'b1; repeat (3) tick();
        bus_master_en = 1'b1; repeat (3) tick();
        irq_event = 1'b0; repeat (2) tick();
        check("R6 no MSI when bme off", pulses - p0, 0);
        check("R6 no legacy when bme off", intx_hits, 0);
        // MSI disabled: legacy pin follows event
        cfg_write(6'h20, 4'b0100, 32'h0000_0000);
        rd(6'h20, "R4 enable cleared", 32'h0000_9005);
        p0 = pulses;
        bus_master_en = 1'b0;
        irq_event = 1'b1; tick();
        check("R7 legacy with bme off", {31'b0, intx_level}, 32'h1);
        bus_master_en = 1'b1; tick();
        check("R7 legacy with bme on", {31'b0, intx_level}, 32'h1);
        irq_event = 1'b0; tick();
        check("R7 legacy drops", {31'b0, intx_level}, 32'h0);
        check("R7 no MSI while disabled", pulses - p0, 0);
        // Unmapped offsets
        rd(6'h22, "R10 read 88h", 32'h0);
        rd(6'h1F, "R10 read 7Ch", 32'h0);
        rd(6'h00, "R10 read 00h", 32'h0);
        cfg_write(6'h22, 4'b1111, 32'hFFFF_FFFF);
        cfg_write(6'h1F, 4'b1111, 32'hFFFF_FFFF);
        rd(6'h20, "R10 control untouched", 32'h0000_9005);
        rd(6'h21, "R10 address untouched", 32'h1234_AB74);
        repeat (2) tick();
        finish_up();
    end
endmodule